// File: doc/BRIEF.md
# Ethernet/IPv4 Streaming Header Extractor

This block watches a byte-wide packet stream and lifts the leading link-layer header, and the network header that follows it when the link-layer type announces IPv4, into parallel field registers. Bytes arrive on a valid/ready handshake that carries start and end markers. A small explicit state graph runs the parse. An idle state waits for a start byte. A link-layer state collects 14 bytes. The type carried in the last two of those bytes decides whether a 20-byte IPv4 state runs or parsing goes straight to a drain state. The drain state swallows the remaining bytes until the end marker.

When the end marker is taken, the block freezes the record, raises a one-cycle completion strobe and holds a pending flag. It also withholds ready until the consumer pulses a take input. Each header has its own valid flag. If the packet ends before a header that should be present is complete, that header stays invalid and a truncation flag is raised. IPv4 options, VLAN tags, checksum verification and payload storage are outside the block.

Top module: `eth_ip_hdr_parser`

## Requirements
- R1: After reset, `in_ready` is 1 and `rec_done`, `rec_pend`, `eth_ok`, `ip_ok` and `trunc` are 0.
- R2: Bytes 0..5 of a packet form `mac_dst`, bytes 6..11 form `mac_src` and bytes 12..13 form `eth_type`. In each field the first received byte is the most significant. `eth_ok` is 1 once 14 bytes are taken.
- R3: When `eth_type` is 16'h0800, bytes 14..33 are split in arrival order, most significant first, as follows: byte 14 bits 7:4 `ip_ver`, bits 3:0 `ip_ihl`; byte 15 `ip_dscp`; bytes 16..17 `ip_len`; 18..19 `ip_id`; byte 20 bits 7:5 `ip_flags`; byte 20 bits 4:0 with byte 21 `ip_frag`; 22 `ip_ttl`; 23 `ip_proto`; 24..25 `ip_csum`; 26..29 `ip_src`; 30..33 `ip_dst`. `ip_ok` is 1 once byte 33 is taken.
- R4: Any other `eth_type` value gives `ip_ok` = 0 and `trunc` = 0, with `eth_ok` = 1.
- R5: Bytes after the last header byte are consumed until the end marker and leave every field unchanged.
- R6: A packet that ends before 14 bytes gives `eth_ok` = 0, `ip_ok` = 0 and `trunc` = 1.
- R7: A packet of type 16'h0800 that ends after 14 bytes but before 34 bytes gives `eth_ok` = 1, `ip_ok` = 0 and `trunc` = 1.
- R8: `rec_done` is high for exactly one cycle, the cycle after the end-marker byte is taken.
- R9: From that cycle until `rec_take` is sampled high, `rec_pend` is 1, `in_ready` is 0 and the record does not change. During a packet `in_ready` is 1.
- R10: While the block is idle, bytes without the start marker are discarded and produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Byte is first of packet |
| in_eop | input | 1 | Byte is last of packet |
| rec_take | input | 1 | Consumer releases the held record |
| rec_done | output | 1 | One-cycle completion strobe |
| rec_pend | output | 1 | Record held and waiting |
| eth_ok | output | 1 | Link-layer header complete |
| ip_ok | output | 1 | IPv4 header complete |
| trunc | output | 1 | Packet ended inside an expected header |
| mac_dst | output | 48 | Destination MAC |
| mac_src | output | 48 | Source MAC |
| eth_type | output | 16 | Type field |
| ip_ver | output | 4 | IP version |
| ip_ihl | output | 4 | Header length in words |
| ip_dscp | output | 8 | Service byte |
| ip_len | output | 16 | Total length |
| ip_id | output | 16 | Identification |
| ip_flags | output | 3 | Fragment flags |
| ip_frag | output | 13 | Fragment offset |
| ip_ttl | output | 8 | Time to live |
| ip_proto | output | 8 | Protocol |
| ip_csum | output | 16 | Header checksum as received |
| ip_src | output | 32 | Source address |
| ip_dst | output | 32 | Destination address |

## Verification
On every cycle, the assertions check the following. A pending record blocks input and stays frozen until it is taken. The completion strobe never lasts two cycles. An IPv4 record always carries a valid link-layer header with the 16'h0800 type and is never flagged truncated. Only the bench scenarios can show field placement and byte order against independently built packets, the exact truncation boundaries at 14 and 34 bytes, the near-miss type values, the draining of trailing bytes, and the discarding of stray bytes before a start marker.

// File: rtl/hp_pkg.sv
package hp_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned ETH_BYTES = 14;
   localparam int unsigned IP_BYTES  = 20;
   localparam logic [15:0] TYPE_IPV4 = 16'h0800;

   typedef enum logic [2:0] {
      PS_START  = 3'd0,
      PS_ETH    = 3'd1,
      PS_IP     = 3'd2,
      PS_ACCEPT = 3'd3,
      PS_HOLD   = 3'd4
   } ps_t;
endpackage

// File: rtl/hp_shreg.sv
module hp_shreg #(
   parameter int unsigned NBYTES = 4,
   parameter int unsigned BW     = 8,
   localparam int unsigned W     = NBYTES * BW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [BW-1:0] din,
   output logic [W-1:0]  q
);
   initial begin
      if (NBYTES < 1) $error("hp_shreg: NBYTES must be at least 1");
   end

   // Lane 0 takes the newest byte; older bytes move up towards the MSB.
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic [BW-1:0] src;
      if (i == 0) begin : g_head
         assign src = din;
      end else begin : g_tail
         assign src = clr ? '0 : q[(i-1)*BW +: BW];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)   q[i*BW +: BW] <= '0;
         else if (en)  q[i*BW +: BW] <= src;
         else if (clr) q[i*BW +: BW] <= '0;
      end
   end
endmodule

// File: rtl/hp_seq.sv
module hp_seq
   import hp_pkg::*;
#(
   parameter int unsigned ETH_N  = ETH_BYTES,
   parameter int unsigned IP_N   = IP_BYTES,
   parameter int unsigned CNT_W  = 6,
   parameter logic [15:0] IP_TYP = TYPE_IPV4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_sop,
   input  logic        in_eop,
   input  logic        rec_take,
   input  logic [15:0] type_now,
   output logic        in_ready,
   output logic        clr,
   output logic        eth_en,
   output logic        ip_en,
   output logic        eth_ok,
   output logic        ip_ok,
   output logic        trunc,
   output logic        done,
   output logic        pend
);
   initial begin
      if (ETH_N < 2 || IP_N < 1) $error("hp_seq: header sizes too small");
      if (ETH_N >= (1 << CNT_W) || IP_N >= (1 << CNT_W)) $error("hp_seq: CNT_W too narrow");
   end

   ps_t              st;
   logic [CNT_W-1:0] cnt;
   logic             beat, first, eth_last, ip_last, is_ip;

   assign in_ready = (st != PS_HOLD);
   assign pend     = (st == PS_HOLD);
   assign beat     = in_valid && in_ready;
   assign first    = beat && (st == PS_START) && in_sop;
   assign clr      = first;
   assign eth_en   = first || (beat && st == PS_ETH);
   assign ip_en    = beat && (st == PS_IP);
   assign eth_last = beat && (st == PS_ETH) && (cnt == CNT_W'(ETH_N - 1));
   assign ip_last  = ip_en && (cnt == CNT_W'(IP_N - 1));
   assign is_ip    = (type_now == IP_TYP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= PS_START; cnt <= '0;
         eth_ok <= 1'b0; ip_ok <= 1'b0; trunc <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            PS_START: if (first) begin
               eth_ok <= 1'b0; ip_ok <= 1'b0;
               trunc  <= in_eop;
               cnt    <= CNT_W'(1);
               if (in_eop) begin st <= PS_HOLD; done <= 1'b1; end
               else st <= PS_ETH;
            end
            PS_ETH: if (beat) begin
               if (eth_last) begin
                  eth_ok <= 1'b1;
                  cnt    <= '0;
                  if (in_eop) begin
                     st <= PS_HOLD; done <= 1'b1; trunc <= is_ip;
                  end else st <= is_ip ? PS_IP : PS_ACCEPT;
               end else if (in_eop) begin
                  st <= PS_HOLD; done <= 1'b1; trunc <= 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            PS_IP: if (beat) begin
               if (ip_last) ip_ok <= 1'b1;
               if (in_eop) begin
                  st <= PS_HOLD; done <= 1'b1; trunc <= !ip_last;
               end else if (ip_last) st <= PS_ACCEPT;
               else cnt <= cnt + 1'b1;
            end
            PS_ACCEPT: if (beat && in_eop) begin
               st <= PS_HOLD; done <= 1'b1;
            end
            PS_HOLD: if (rec_take) st <= PS_START;
            default: st <= PS_START;
         endcase
      end
   end

   // R8: completion strobe lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: a held record blocks the input
   p_hold_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !in_ready);
   // R9: the strobe always starts a held record
   p_done_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend);
   // R7: truncation never coexists with a complete IPv4 header
   p_ip_not_trunc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && ip_ok) |-> (!trunc && eth_ok));
endmodule

// File: rtl/eth_ip_hdr_parser.sv
module eth_ip_hdr_parser
   import hp_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [7:0]  in_data,
   input  logic        in_sop,
   input  logic        in_eop,
   input  logic        rec_take,
   output logic        rec_done,
   output logic        rec_pend,
   output logic        eth_ok,
   output logic        ip_ok,
   output logic        trunc,
   output logic [47:0] mac_dst,
   output logic [47:0] mac_src,
   output logic [15:0] eth_type,
   output logic [3:0]  ip_ver,
   output logic [3:0]  ip_ihl,
   output logic [7:0]  ip_dscp,
   output logic [15:0] ip_len,
   output logic [15:0] ip_id,
   output logic [2:0]  ip_flags,
   output logic [12:0] ip_frag,
   output logic [7:0]  ip_ttl,
   output logic [7:0]  ip_proto,
   output logic [15:0] ip_csum,
   output logic [31:0] ip_src,
   output logic [31:0] ip_dst
);
   localparam int unsigned EW = ETH_BYTES * BYTE_W;
   localparam int unsigned IW = IP_BYTES * BYTE_W;

   logic [EW-1:0] eth_q;
   logic [IW-1:0] ip_q;
   logic          clr, eth_en, ip_en;
   logic [15:0]   type_now;

   assign type_now = {eth_q[7:0], in_data};

   hp_seq #(.ETH_N(ETH_BYTES), .IP_N(IP_BYTES), .CNT_W(CNT_W), .IP_TYP(TYPE_IPV4)) u_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .rec_take(rec_take), .type_now(type_now), .in_ready(in_ready), .clr(clr),
      .eth_en(eth_en), .ip_en(ip_en), .eth_ok(eth_ok), .ip_ok(ip_ok), .trunc(trunc),
      .done(rec_done), .pend(rec_pend)
   );

   hp_shreg #(.NBYTES(ETH_BYTES), .BW(BYTE_W)) u_eth_sr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(eth_en), .din(in_data), .q(eth_q)
   );

   hp_shreg #(.NBYTES(IP_BYTES), .BW(BYTE_W)) u_ip_sr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(ip_en), .din(in_data), .q(ip_q)
   );

   assign mac_dst  = eth_q[111:64];
   assign mac_src  = eth_q[63:16];
   assign eth_type = eth_q[15:0];

   assign ip_ver   = ip_q[159:156];
   assign ip_ihl   = ip_q[155:152];
   assign ip_dscp  = ip_q[151:144];
   assign ip_len   = ip_q[143:128];
   assign ip_id    = ip_q[127:112];
   assign ip_flags = ip_q[111:109];
   assign ip_frag  = ip_q[108:96];
   assign ip_ttl   = ip_q[95:88];
   assign ip_proto = ip_q[87:80];
   assign ip_csum  = ip_q[79:64];
   assign ip_src   = ip_q[63:32];
   assign ip_dst   = ip_q[31:0];

   // R9: a held record does not change until it is taken
   p_rec_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_pend && !rec_take) |=> (rec_pend && $stable(eth_q) && $stable(ip_q)));
   // R3: an IPv4 record carries the IPv4 type and a valid link header
   p_ip_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_pend && ip_ok) |-> (eth_ok && eth_type == TYPE_IPV4));
   // R4: a complete non-IPv4 link header is never truncated
   p_other_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_pend && eth_ok && eth_type != TYPE_IPV4) |-> (!ip_ok && !trunc));
endmodule

// File: tb/eth_ip_hdr_parser_bench.sv
module eth_ip_hdr_parser_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_sop, in_eop, rec_take;
   logic [7:0]  in_data;
   logic        in_ready, rec_done, rec_pend, eth_ok, ip_ok, trunc;
   logic [47:0] mac_dst, mac_src;
   logic [15:0] eth_type, ip_len, ip_id, ip_csum;
   logic [3:0]  ip_ver, ip_ihl;
   logic [7:0]  ip_dscp, ip_ttl, ip_proto;
   logic [2:0]  ip_flags;
   logic [12:0] ip_frag;
   logic [31:0] ip_src, ip_dst;

   int checks = 0;
   int errors = 0;
   logic [7:0] pk [0:63];

   always #2 clk = ~clk;

   eth_ip_hdr_parser u_eth_ip_hdr_parser (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .rec_take(rec_take),
      .rec_done(rec_done), .rec_pend(rec_pend), .eth_ok(eth_ok), .ip_ok(ip_ok),
      .trunc(trunc), .mac_dst(mac_dst), .mac_src(mac_src), .eth_type(eth_type),
      .ip_ver(ip_ver), .ip_ihl(ip_ihl), .ip_dscp(ip_dscp), .ip_len(ip_len),
      .ip_id(ip_id), .ip_flags(ip_flags), .ip_frag(ip_frag), .ip_ttl(ip_ttl),
      .ip_proto(ip_proto), .ip_csum(ip_csum), .ip_src(ip_src), .ip_dst(ip_dst)
   );

   task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic build(input int len, input logic [15:0] typ, input int seed);
      for (int i = 0; i < 64; i++) pk[i] = 8'((seed * 37 + i * 11 + 5) ^ (i << 3));
      pk[12] = typ[15:8];
      pk[13] = typ[7:0];
      if (len < 0) pk[0] = 8'h00;
   endtask

   task automatic send(input int len, input logic [15:0] typ, input string tag);
      logic e_eth, e_isip, e_ip, e_tr;
      logic [159:0] e_ipv;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = pk[i];
         in_sop = (i == 0); in_eop = (i == len - 1);
         chk("R9 ready during packet", {159'd0, in_ready}, 160'd1);
      end
      @(negedge clk);
      // junk while held: must be refused
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'hA5;
      chk("R8 done after eop", {159'd0, rec_done}, 160'd1);
      chk("R9 pend and not ready", {158'd0, rec_pend, in_ready}, {158'd0, 2'b10});
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      chk("R8 done single cycle", {159'd0, rec_done}, 160'd0);
      e_eth  = (len >= 14);
      e_isip = e_eth && (typ == 16'h0800);
      e_ip   = e_isip && (len >= 34);
      e_tr   = (len < 14) || (e_isip && len < 34);
      chk({tag, " flags"}, {157'd0, eth_ok, ip_ok, trunc}, {157'd0, e_eth, e_ip, e_tr});
      if (e_eth) begin
         chk("R2 link fields", {48'd0, mac_dst, mac_src, eth_type},
             {48'd0, pk[0], pk[1], pk[2], pk[3], pk[4], pk[5],
              pk[6], pk[7], pk[8], pk[9], pk[10], pk[11], pk[12], pk[13]});
      end
      if (e_ip) begin
         e_ipv = '0;
         for (int i = 14; i < 34; i++) e_ipv = {e_ipv[151:0], pk[i]};
         chk("R3 ipv4 fields", {ip_ver, ip_ihl, ip_dscp, ip_len, ip_id, ip_flags, ip_frag,
             ip_ttl, ip_proto, ip_csum, ip_src, ip_dst}, e_ipv);
      end
      @(negedge clk);
      chk("R9 still held", {159'd0, rec_pend}, 160'd1);
      rec_take = 1'b1;
      @(negedge clk);
      rec_take = 1'b0;
      chk("R9 released", {158'd0, rec_pend, in_ready}, {158'd0, 2'b01});
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      in_data = 8'h00; rec_take = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", {154'd0, in_ready, rec_done, rec_pend, eth_ok, ip_ok, trunc},
          {154'd0, 6'b100000});

      // R3 R5 R6 R7: IPv4 type, every length 1..40
      for (int len = 1; len <= 40; len++) begin
         build(len, 16'h0800, len);
         send(len, 16'h0800, len < 14 ? "R6" : (len < 34 ? "R7" : (len > 34 ? "R5" : "R3")));
      end
      // R4 R6: other and near-miss types
      for (int len = 1; len <= 20; len++) begin
         build(len, 16'h86DD, len + 100);
         send(len, 16'h86DD, len < 14 ? "R6" : "R4");
         build(len, 16'h0801, len + 200);
         send(len, 16'h0801, len < 14 ? "R6" : "R4");
         build(len, 16'h0008, len + 300);
         send(len, 16'h0008, len < 14 ? "R6" : "R4");
      end

      // R10: stray bytes without start marker while idle
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = 1'b0; in_eop = (k == 3); in_data = 8'(8'h30 + k);
      end
      @(negedge clk);
      in_valid = 1'b0; in_eop = 1'b0;
      chk("R10 stray bytes ignored", {158'd0, rec_done, rec_pend}, 160'd0);
      @(negedge clk);
      chk("R10 still idle", {158'd0, rec_pend, in_ready}, {158'd0, 2'b01});
      build(34, 16'h0800, 77);
      send(34, 16'h0800, "R10");

      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule